// File: doc/BRIEF.md
# Two-Port Wired-OR GPIO

This block holds the pin state of two general-purpose ports, A and B, with 16 pins each, behind a small word-addressed register bus. Every pin is driven from one of three places: the CPU, through a per-port data register and a direction bit; a shared peripheral agent, through a set of data and direction values loaded from outside; or a pull-up, which takes the pin only when neither side drives it. The level a pin takes is the OR of these three, and reading a data register returns that level, not the value last written.

Whenever a CPU write or a peripheral load changes the level of any pin, the block reports which pins flipped. Up to four peripheral slots, each with a valid bit and one trigger mask per port, receive a one-cycle pulse when their masks cover a flipped pin. A notified agent sees the current levels of both ports on dedicated outputs and may answer with a new peripheral load. Writing a non-zero value to the pin-interrupt configuration word is not supported; the block flags it with a one-cycle error pulse.

Top module: `gpio2_wired`

## Requirements
- R1: In a port's 32-bit control word, bit 2n enables the CPU output on pin n and bit 2n+1 enables the pull-up of pin n.
- R2: A port's level is (cpuDir & cpuData) | (perDir & perData) | (~(cpuDir | perDir) & pullUp), bit by bit, visible in the cycle after the register edge that changed any term.
- R3: A pin driven by neither the CPU nor the peripheral shows its pull-up bit; a pin the CPU drives low reads 0 even with its pull-up enabled.
- R4: Word address 2 (port A data) and 3 (port B data) read back the resolved levels; writes there keep only the low 16 bits of the bus word.
- R5: Word address 0 (port A control) and 1 (port B control) read back the last 32-bit word written; address 4 and every unmapped address read 0.
- R6: A write or load that leaves both ports' levels unchanged produces no pulse and zero changed-pin vectors.
- R7: After an edge that changes levels, the changed-pin vectors of both ports equal old XOR new levels for exactly one cycle, then return to 0.
- R8: Slot s pulses in that cycle only if its valid bit is 1 and (maskA & changedA) | (maskB & changedB) is non-zero; an invalid slot never pulses.
- R9: A peripheral load strobe captures all four peripheral data and direction inputs at once and feeds the same change detection as a CPU write.
- R10: A write of a non-zero word to address 4 raises the error output for the one following cycle; a write of zero there does not.
- R11: After reset all control, data and peripheral registers are 0, so every pin reads 0 and no slot pulses.
- R12: The resolved levels of both ports are always present on the level outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Word address of read or write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| periphLoad | input | 1 | Load strobe for the peripheral drive values |
| periphDataA | input | 16 | Peripheral data for port A |
| periphDirA | input | 16 | Peripheral drive enables for port A |
| periphDataB | input | 16 | Peripheral data for port B |
| periphDirB | input | 16 | Peripheral drive enables for port B |
| slotValid | input | NUM_SLOTS | Slot holds a registered agent |
| slotMaskA | input | 16*NUM_SLOTS | Port A trigger masks, slot s at bits 16s+15..16s |
| slotMaskB | input | 16*NUM_SLOTS | Port B trigger masks, slot s at bits 16s+15..16s |
| levelA | output | 16 | Resolved levels of port A |
| levelB | output | 16 | Resolved levels of port B |
| changedA | output | 16 | Port A pins flipped by the last edge |
| changedB | output | 16 | Port B pins flipped by the last edge |
| notify | output | NUM_SLOTS | One-cycle pulse per triggered slot |
| irqCfgErr | output | 1 | Unsupported interrupt configuration write |

## Verification
The hardest case to reach is a write that changes a register but not the level, for instance a data write to a pin that is an input, or a control write that toggles a pull-up under a pin the peripheral already drives. The directed part writes all ones to a data register whose pins are mostly inputs and then repeats the same word, and the random part draws writes from a small value pool so that repeated and level-neutral writes occur often, with the masks and valid bits reshuffled so that each slot sees both overlapping and disjoint changes.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;
  localparam int PINS   = 16;
  localparam int CTRL_W = 2 * PINS;
  localparam int NPORT  = 2;

  localparam int ADDR_CTRL_A = 0;
  localparam int ADDR_CTRL_B = 1;
  localparam int ADDR_DATA_A = 2;
  localparam int ADDR_DATA_B = 3;
  localparam int ADDR_IRQCFG = 4;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTRL_A,
    RD_CTRL_B,
    RD_LVL_A,
    RD_LVL_B
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrlA;
    logic   wrCtrlB;
    logic   wrDataA;
    logic   wrDataB;
    logic   ldPeriph;
    rdSel_e rdSel;
  } gpioStrb_t;
endpackage

// File: rtl/gpio2_ctrl.sv
module gpio2_ctrl
  import gpio2_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTRL_W-1:0] busWrData,
  input  logic              periphLoad,
  output gpioStrb_t         strb,
  output logic              irqCfgErr
);
  logic hitCtrlA, hitCtrlB, hitDataA, hitDataB, hitIrq;

  always_comb begin
    hitCtrlA = (busAddr == ADDR_W'(ADDR_CTRL_A));
    hitCtrlB = (busAddr == ADDR_W'(ADDR_CTRL_B));
    hitDataA = (busAddr == ADDR_W'(ADDR_DATA_A));
    hitDataB = (busAddr == ADDR_W'(ADDR_DATA_B));
    hitIrq   = (busAddr == ADDR_W'(ADDR_IRQCFG));

    strb.wrCtrlA  = busWrEn && hitCtrlA;
    strb.wrCtrlB  = busWrEn && hitCtrlB;
    strb.wrDataA  = busWrEn && hitDataA;
    strb.wrDataB  = busWrEn && hitDataB;
    strb.ldPeriph = periphLoad;

    if (hitCtrlA)      strb.rdSel = RD_CTRL_A;
    else if (hitCtrlB) strb.rdSel = RD_CTRL_B;
    else if (hitDataA) strb.rdSel = RD_LVL_A;
    else if (hitDataB) strb.rdSel = RD_LVL_B;
    else               strb.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqCfgErr <= 1'b0;
    else       irqCfgErr <= busWrEn && hitIrq && (busWrData != '0);
  end

  AST_IRQ_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqCfgErr |-> ($past(busWrEn) && ($past(busAddr) == ADDR_W'(ADDR_IRQCFG))
                   && ($past(busWrData) != '0))); // R10

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrlA, strb.wrCtrlB, strb.wrDataA, strb.wrDataB})); // R5
endmodule

// File: rtl/gpio2_dpath.sv
module gpio2_dpath
  import gpio2_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  gpioStrb_t                 strb,
  input  logic [CTRL_W-1:0]         busWrData,
  input  logic [PINS-1:0]           periphDataA,
  input  logic [PINS-1:0]           periphDirA,
  input  logic [PINS-1:0]           periphDataB,
  input  logic [PINS-1:0]           periphDirB,
  input  logic [NUM_SLOTS-1:0]      slotValid,
  input  logic [NUM_SLOTS*PINS-1:0] slotMaskA,
  input  logic [NUM_SLOTS*PINS-1:0] slotMaskB,
  output logic [CTRL_W-1:0]         rdData,
  output logic [PINS-1:0]           levelA,
  output logic [PINS-1:0]           levelB,
  output logic [PINS-1:0]           changedA,
  output logic [PINS-1:0]           changedB,
  output logic [NUM_SLOTS-1:0]      notify
);
  logic [NPORT-1:0][CTRL_W-1:0] ctrlQ;
  logic [NPORT-1:0][PINS-1:0]   dataQ, perDatQ, perDirQ, lvlQ;
  logic [NPORT-1:0][PINS-1:0]   cpuDir, pullUp, lvl, chg;
  logic [NPORT-1:0][PINS-1:0]   perDatIn, perDirIn;
  logic [NPORT-1:0]             wrCtrl, wrData;
  logic                         anyStrb;

  assign wrCtrl   = {strb.wrCtrlB, strb.wrCtrlA};
  assign wrData   = {strb.wrDataB, strb.wrDataA};
  assign perDatIn = {periphDataB, periphDataA};
  assign perDirIn = {periphDirB, periphDirA};
  assign anyStrb  = (|wrCtrl) | (|wrData) | strb.ldPeriph;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      dataQ   <= '0;
      perDatQ <= '0;
      perDirQ <= '0;
      lvlQ    <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (wrCtrl[p]) ctrlQ[p] <= busWrData;
        if (wrData[p]) dataQ[p] <= busWrData[PINS-1:0];
        if (strb.ldPeriph) begin
          perDatQ[p] <= perDatIn[p];
          perDirQ[p] <= perDirIn[p];
        end
        lvlQ[p] <= lvl[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      for (int n = 0; n < PINS; n++) begin
        cpuDir[p][n] = ctrlQ[p][2*n];
        pullUp[p][n] = ctrlQ[p][2*n+1];
      end
      lvl[p] = (cpuDir[p] & dataQ[p])
             | (perDirQ[p] & perDatQ[p])
             | (~(cpuDir[p] | perDirQ[p]) & pullUp[p]);
      chg[p] = lvl[p] ^ lvlQ[p];
    end
  end

  assign levelA   = lvl[0];
  assign levelB   = lvl[1];
  assign changedA = chg[0];
  assign changedB = chg[1];

  always_comb begin
    case (strb.rdSel)
      RD_CTRL_A: rdData = ctrlQ[0];
      RD_CTRL_B: rdData = ctrlQ[1];
      RD_LVL_A:  rdData = {{(CTRL_W-PINS){1'b0}}, lvl[0]};
      RD_LVL_B:  rdData = {{(CTRL_W-PINS){1'b0}}, lvl[1]};
      default:   rdData = '0;
    endcase
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic [PINS-1:0] hitA, hitB;
    assign hitA      = slotMaskA[s*PINS +: PINS] & chg[0];
    assign hitB      = slotMaskB[s*PINS +: PINS] & chg[1];
    assign notify[s] = slotValid[s] && ((hitA | hitB) != '0);

    AST_SLOT_GATED: assert property (@(posedge clk) disable iff (!rstN)
      notify[s] |-> slotValid[s]); // R8
  end

  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(anyStrb) |-> (chg == '0)); // R6

  AST_CHANGE_IS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ((chg != '0) && !anyStrb) |=> (chg == '0)); // R7
endmodule

// File: rtl/gpio2_wired.sv
module gpio2_wired
  import gpio2_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [31:0]               busWrData,
  output logic [31:0]               busRdData,
  input  logic                      periphLoad,
  input  logic [15:0]               periphDataA,
  input  logic [15:0]               periphDirA,
  input  logic [15:0]               periphDataB,
  input  logic [15:0]               periphDirB,
  input  logic [NUM_SLOTS-1:0]      slotValid,
  input  logic [16*NUM_SLOTS-1:0]   slotMaskA,
  input  logic [16*NUM_SLOTS-1:0]   slotMaskB,
  output logic [15:0]               levelA,
  output logic [15:0]               levelB,
  output logic [15:0]               changedA,
  output logic [15:0]               changedB,
  output logic [NUM_SLOTS-1:0]      notify,
  output logic                      irqCfgErr
);
  gpioStrb_t strb;

  gpio2_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .periphLoad(periphLoad),
    .strb(strb), .irqCfgErr(irqCfgErr)
  );

  gpio2_dpath #(.NUM_SLOTS(NUM_SLOTS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .periphDataA(periphDataA), .periphDirA(periphDirA),
    .periphDataB(periphDataB), .periphDirB(periphDirB),
    .slotValid(slotValid), .slotMaskA(slotMaskA), .slotMaskB(slotMaskB),
    .rdData(busRdData), .levelA(levelA), .levelB(levelB),
    .changedA(changedA), .changedB(changedB), .notify(notify)
  );
endmodule

// File: tb/sim_gpio2_wired.sv
module sim_gpio2_wired;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          busWrEn = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          periphLoad = 1'b0;
  logic [15:0]   pDatA = '0, pDirA = '0, pDatB = '0, pDirB = '0;
  logic [NS-1:0] slotValid = '0;
  logic [16*NS-1:0] maskA = '0, maskB = '0;
  logic [15:0]   levelA, levelB, changedA, changedB;
  logic [NS-1:0] notify;
  logic          irqCfgErr;

  gpio2_wired #(.NUM_SLOTS(NS), .ADDR_W(3)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .periphLoad(periphLoad),
    .periphDataA(pDatA), .periphDirA(pDirA), .periphDataB(pDatB), .periphDirB(pDirB),
    .slotValid(slotValid), .slotMaskA(maskA), .slotMaskB(maskB),
    .levelA(levelA), .levelB(levelB), .changedA(changedA), .changedB(changedB),
    .notify(notify), .irqCfgErr(irqCfgErr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit [31:0] mCtrl [2];
  bit [15:0] mData [2];
  bit [15:0] mPDat [2];
  bit [15:0] mPDir [2];
  bit [15:0] mChg  [2];
  bit        mErr;

  function automatic bit [15:0] pinLevels(int p);
    bit [15:0] r;
    for (int n = 0; n < 16; n++) begin
      bit outEn, pu;
      outEn = mCtrl[p][2*n];
      pu    = mCtrl[p][2*n+1];
      if (outEn && mData[p][n])            r[n] = 1'b1;
      else if (mPDir[p][n] && mPDat[p][n]) r[n] = 1'b1;
      else if (!outEn && !mPDir[p][n])     r[n] = pu;
      else                                 r[n] = 1'b0;
    end
    return r;
  endfunction

  function automatic bit [31:0] readExp(bit [2:0] a);
    case (a)
      3'd0: return mCtrl[0];
      3'd1: return mCtrl[1];
      3'd2: return {16'h0, pinLevels(0)};
      3'd3: return {16'h0, pinLevels(1)};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit [NS-1:0] notifyExp();
    bit [NS-1:0] r;
    for (int s = 0; s < NS; s++) begin
      bit [15:0] ma, mb;
      ma = maskA[16*s +: 16];
      mb = maskB[16*s +: 16];
      r[s] = slotValid[s] && (((ma & mChg[0]) != 0) || ((mb & mChg[1]) != 0));
    end
    return r;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit [15:0] old0, old1;
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        mCtrl[p] = 0; mData[p] = 0; mPDat[p] = 0; mPDir[p] = 0; mChg[p] = 0;
      end
      mErr = 0;
      return;
    end
    old0 = pinLevels(0);
    old1 = pinLevels(1);
    if (busWrEn) begin
      case (busAddr)
        3'd0: mCtrl[0] = busWrData;
        3'd1: mCtrl[1] = busWrData;
        3'd2: mData[0] = busWrData[15:0];
        3'd3: mData[1] = busWrData[15:0];
        default: ;
      endcase
    end
    if (periphLoad) begin
      mPDat[0] = pDatA; mPDir[0] = pDirA;
      mPDat[1] = pDatB; mPDir[1] = pDirB;
    end
    mErr = busWrEn && (busAddr == 3'd4) && (busWrData != 0);
    mChg[0] = old0 ^ pinLevels(0);
    mChg[1] = old1 ^ pinLevels(1);
  endtask

  // one clock: DUT and model take the edge, then everything is compared
  task automatic tick();
    @(posedge clk);
    modelEdge();
    #1;
    if (busAddr == 3'd2 || busAddr == 3'd3) cmp("R4 read data", busRdData, readExp(busAddr));
    else                                    cmp("R5 read ctrl", busRdData, readExp(busAddr));
    cmp("R2 levelA", {16'h0, levelA}, {16'h0, pinLevels(0)});
    cmp("R12 levelB", {16'h0, levelB}, {16'h0, pinLevels(1)});
    cmp("R7 changedA", {16'h0, changedA}, {16'h0, mChg[0]});
    cmp("R7 changedB", {16'h0, changedB}, {16'h0, mChg[1]});
    cmp("R8 notify", {28'h0, notify}, {28'h0, notifyExp()});
    cmp("R10 irqCfgErr", {31'h0, irqCfgErr}, {31'h0, mErr});
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic ld(bit [15:0] da, bit [15:0] ra, bit [15:0] db, bit [15:0] rb);
    periphLoad = 1'b1; pDatA = da; pDirA = ra; pDatB = db; pDirB = rb;
    tick();
    periphLoad = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    tick(); tick();
    // R11: reset state
    cmp("R11 levels after reset", {levelA, levelB}, 32'h0);
    cmp("R11 notify after reset", {28'h0, notify}, 32'h0);
    rstN = 1'b1;
    tick();

    slotValid = 4'b0111;
    maskA = {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001};
    maskB = {16'hFFFF, 16'hFFFF, 16'h8000, 16'h0000};

    // R1/R3: pull-up on pin 0 only (bit 1)
    wr(3'd0, 32'h0000_0002);
    cmp("R1 pull-up bit 2n+1", {16'h0, levelA}, 32'h1);
    cmp("R3 undriven pin shows pull-up", {16'h0, changedA}, 32'h1);
    cmp("R8 valid overlapping slots only", {28'h0, notify}, 32'h5);

    // R1/R3: drive pin 0 low with pull-up still enabled
    wr(3'd0, 32'h0000_0003);
    cmp("R3 driven low beats pull-up", {16'h0, levelA}, 32'h0);

    // R4: data write of all ones, only pin 0 is an output
    wr(3'd2, 32'hFFFF_FFFF);
    cmp("R4 read returns levels not written word", busRdData, 32'h1);

    // R6: same word again changes nothing
    wr(3'd2, 32'h0000_FFFF);
    cmp("R6 no pulse on unchanged levels", {28'h0, notify}, 32'h0);
    cmp("R6 no changed pins", {changedA, changedB}, 32'h0);

    // R9: peripheral drives port B pin 15 high
    ld(16'h0000, 16'h0000, 16'h8000, 16'h8000);
    cmp("R9 peripheral load sets level", {16'h0, levelB}, 32'h8000);
    cmp("R9 peripheral load notifies", {28'h0, notify}, 32'h6);
    tick();
    cmp("R7 change lasts one cycle", {changedA, changedB}, 32'h0);

    // R10: interrupt configuration
    wr(3'd4, 32'h5);
    cmp("R10 non-zero write flagged", {31'h0, irqCfgErr}, 32'h1);
    wr(3'd4, 32'h0);
    cmp("R10 zero write not flagged", {31'h0, irqCfgErr}, 32'h0);

    // R5: control read-back
    busAddr = 3'd0;
    tick();
    cmp("R5 control read-back", busRdData, 32'h3);
    busAddr = 3'd6;
    tick();
    cmp("R5 unmapped reads zero", busRdData, 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] pool [4];
      pool[0] = 32'h0; pool[1] = 32'hFFFF_FFFF; pool[2] = 32'hAAAA_AAAA; pool[3] = 32'h5555_5555;
      if (($urandom % 64) == 0) begin
        slotValid = NS'($urandom);
        maskA = {$urandom, $urandom};
        maskB = {$urandom, $urandom};
      end
      busWrEn   = ($urandom % 2) == 0;
      busAddr   = 3'($urandom % 6);
      busWrData = (($urandom % 2) == 0) ? pool[$urandom % 4] : $urandom;
      periphLoad = ($urandom % 4) == 0;
      if (periphLoad) begin
        pDatA = 16'($urandom); pDirA = 16'($urandom & $urandom);
        pDatB = 16'($urandom); pDirB = 16'($urandom & $urandom);
      end
      tick();
    end
    busWrEn = 1'b0;
    periphLoad = 1'b0;
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule